// File: doc/BRIEF.md
# Signed Halfword-Select Multiply Unit

This block is a registered signed multiply datapath with two operation families. In halfword mode it takes one 16-bit half from each of two 32-bit operands, treats both halves as signed, and returns their full 32-bit signed product. In word-by-halfword mode it multiplies the whole first operand, as a signed 32-bit value, by one signed 16-bit half of the second operand. It then returns the upper 32 bits of the 48-bit product.

A caller presents both operands, a mode bit and two half-select bits, and pulses an execute strobe. On the next rising clock edge the result register loads and the output valid flag rises for one cycle. A two-state controller tracks this. ST_IDLE means no fresh result is present. ST_DONE means a result was loaded on the last edge. The transitions are: IDLE→DONE on a strobe (GO), DONE→DONE on a back-to-back strobe (AGAIN), DONE→IDLE with no strobe (RETIRE), and IDLE→IDLE with no strobe (WAIT). Reset forces IDLE from any state.

Top module: `hsel_mul_unit`

## Requirements
- R1: In halfword mode (`mode_word_i`=0), `sel_a_hi_i`=0 uses `opa_i[15:0]` as the first factor and `sel_a_hi_i`=1 uses `opa_i[31:16]`.
- R2: In both modes, `sel_b_hi_i`=0 uses `opb_i[15:0]` as the second factor and `sel_b_hi_i`=1 uses `opb_i[31:16]`.
- R3: In halfword mode, the result is the complete 32-bit two's-complement product of the two selected halves, each read as a signed 16-bit integer.
- R4: In word-by-halfword mode (`mode_word_i`=1), the result is bits [47:16] of the 48-bit signed product of `opa_i`, read as signed 32-bit, and the selected half of `opb_i`.
- R5: In word-by-halfword mode, `sel_a_hi_i` has no effect on the result.
- R6: In halfword mode, -32768 × -32768 (0x8000 by 0x8000) yields 0x40000000, with no saturation and no flag.
- R7: When `exec_i` is high at a rising edge, `result_o` holds the new result after that edge and `result_vld_o` is high for exactly the following cycle. With back-to-back strobes, `result_vld_o` stays high and the result takes new values each cycle.
- R8: When `exec_i` is low at a rising edge, `result_o` keeps its value and `result_vld_o` is low after that edge.
- R9: An active-low synchronous reset (`rst_n`=0 at an edge) clears `result_o` to zero and `result_vld_o` to 0. Reset takes priority over `exec_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| exec_i | input | 1 | Execute strobe; loads a new result |
| mode_word_i | input | 1 | 0 = halfword mode, 1 = word-by-halfword mode |
| sel_a_hi_i | input | 1 | First operand half select: 0 bottom, 1 top (halfword mode only) |
| sel_b_hi_i | input | 1 | Second operand half select: 0 bottom, 1 top |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand |
| result_o | output | 32 | Registered result |
| result_vld_o | output | 1 | High for one cycle after each strobe |

## Verification
Every result and its valid flag are due exactly one rising edge after the edge that samples `exec_i` high. Nothing is produced in the same cycle, and nothing appears two cycles later. The bench drives inputs on the falling edge, lets one rising edge pass, and samples `result_o` and `result_vld_o` on the next falling edge. One further falling edge with the strobe low confirms that the valid flag has dropped and the result has held. Reset checks follow the same one-edge rule.

// File: rtl/hsel_mul_pkg.sv
package hsel_mul_pkg;
    parameter int unsigned DATA_W = 32;
    localparam int unsigned HALF_W = DATA_W / 2;
    localparam int unsigned WIDE_W = DATA_W + HALF_W;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } ctl_state_e;

    typedef enum logic {
        MODE_HALF = 1'b0,
        MODE_WORD = 1'b1
    } mul_mode_e;
endpackage

// File: rtl/hsel_half_pick.sv
module hsel_half_pick #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0]   word_i,
    input  logic           hi_i,
    output logic [W/2-1:0] half_o
);
    localparam int unsigned H = W / 2;

    always_comb begin
        half_o = hi_i ? word_i[W-1:H] : word_i[H-1:0];
    end
endmodule

// File: rtl/hsel_mul_core.sv
module hsel_mul_core #(
    parameter int unsigned W = 32
) (
    input  logic           word_mode_i,
    input  logic [W-1:0]   full_a_i,
    input  logic [W/2-1:0] half_a_i,
    input  logic [W/2-1:0] half_b_i,
    output logic [W-1:0]   prod_o
);
    localparam int unsigned H  = W / 2;
    localparam int unsigned WW = W + H;

    logic signed [W-1:0]  hh_a, hh_b, hh_prod;
    logic signed [WW-1:0] wh_a, wh_b, wh_prod;
    logic [H-1:0]         wh_unused_lo;

    always_comb begin
        hh_a    = {{H{half_a_i[H-1]}}, half_a_i};
        hh_b    = {{H{half_b_i[H-1]}}, half_b_i};
        hh_prod = hh_a * hh_b;
        wh_a    = {{H{full_a_i[W-1]}}, full_a_i};
        wh_b    = {{W{half_b_i[H-1]}}, half_b_i};
        wh_prod = wh_a * wh_b;
        wh_unused_lo = wh_prod[H-1:0];
        prod_o  = word_mode_i ? wh_prod[WW-1:H] : hh_prod;
    end
endmodule

// File: rtl/hsel_mul_unit.sv
module hsel_mul_unit
    import hsel_mul_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         exec_i,
    input  logic         mode_word_i,
    input  logic         sel_a_hi_i,
    input  logic         sel_b_hi_i,
    input  logic [W-1:0] opa_i,
    input  logic [W-1:0] opb_i,
    output logic [W-1:0] result_o,
    output logic         result_vld_o
);
    localparam int unsigned H = W / 2;

    ctl_state_e   state_q, state_d;
    logic [H-1:0] half_a, half_b;
    logic [W-1:0] prod;
    mul_mode_e    mode;

    assign mode = mul_mode_e'(mode_word_i);

    hsel_half_pick #(.W(W)) u_pick_a (
        .word_i (opa_i),
        .hi_i   (sel_a_hi_i),
        .half_o (half_a)
    );

    hsel_half_pick #(.W(W)) u_pick_b (
        .word_i (opb_i),
        .hi_i   (sel_b_hi_i),
        .half_o (half_b)
    );

    hsel_mul_core #(.W(W)) u_core (
        .word_mode_i (mode == MODE_WORD),
        .full_a_i    (opa_i),
        .half_a_i    (half_a),
        .half_b_i    (half_b),
        .prod_o      (prod)
    );

    // next-state logic: GO, AGAIN, RETIRE, WAIT
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = exec_i ? ST_DONE : ST_IDLE;
            ST_DONE: state_d = exec_i ? ST_DONE : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // result register
    always_ff @(posedge clk) begin
        if (!rst_n)      result_o <= '0;
        else if (exec_i) result_o <= prod;
    end

    // outputs
    always_comb begin
        result_vld_o = (state_q == ST_DONE);
    end

    assert_reset_clear_R9: assert property (@(posedge clk)
        !rst_n |=> (result_o == '0 && !result_vld_o));

    assert_vld_after_exec_R7: assert property (@(posedge clk) disable iff (!rst_n)
        exec_i |=> result_vld_o);

    assert_vld_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_i |=> !result_vld_o);

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_i |=> $stable(result_o));

    assert_min_min_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && !mode_word_i && half_a == {1'b1, {(H-1){1'b0}}}
                && half_b == {1'b1, {(H-1){1'b0}}})
        |=> result_o == {2'b01, {(W-2){1'b0}}});

    assert_word_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && mode_word_i && opa_i != '0 && half_b != '0)
        |=> result_o[W-1] == ($past(opa_i[W-1]) ^ $past(half_b[H-1])));
endmodule

// File: tb/hsel_mul_unit_bench.sv
module hsel_mul_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exec_i = 1'b0;
    logic        mode_word_i = 1'b0;
    logic        sel_a_hi_i = 1'b0;
    logic        sel_b_hi_i = 1'b0;
    logic [31:0] opa_i = '0;
    logic [31:0] opb_i = '0;
    logic [31:0] result_o;
    logic        result_vld_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    hsel_mul_unit u_hsel_mul_unit (
        .clk (clk), .rst_n (rst_n), .exec_i (exec_i),
        .mode_word_i (mode_word_i), .sel_a_hi_i (sel_a_hi_i),
        .sel_b_hi_i (sel_b_hi_i), .opa_i (opa_i), .opb_i (opb_i),
        .result_o (result_o), .result_vld_o (result_vld_o)
    );

    logic [15:0] corner [4] = '{16'h8000, 16'h7FFF, 16'hFFFF, 16'h0000};

    function automatic logic [31:0] ref_calc(bit m, bit sa, bit sb,
                                             logic [31:0] a, logic [31:0] b);
        logic signed [63:0] fa, fb, p;
        fb = sb ? 64'($signed(b[31:16])) : 64'($signed(b[15:0]));
        if (m) begin
            fa = 64'($signed(a));
            p  = fa * fb;
            return p[47:16];
        end
        fa = sa ? 64'($signed(a[31:16])) : 64'($signed(a[15:0]));
        p  = fa * fb;
        return p[31:0];
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(string req, bit m, bit sa, bit sb,
                          logic [31:0] a, logic [31:0] b);
        @(negedge clk);
        mode_word_i = m; sel_a_hi_i = sa; sel_b_hi_i = sb;
        opa_i = a; opb_i = b; exec_i = 1'b1;
        @(negedge clk);
        exec_i = 1'b0;
        check(req, result_o, ref_calc(m, sa, sb, a, b));
        check({req, " valid"}, {31'd0, result_vld_o}, 32'd1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        exec_i = 1'b1; opa_i = 32'h7FFF7FFF; opb_i = 32'h7FFF7FFF;
        repeat (2) @(negedge clk);
        check("R9 result", result_o, 32'd0);
        check("R9 valid", {31'd0, result_vld_o}, 32'd0);
        exec_i = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_halfword();
        for (int v = 0; v < 4; v++)
            for (int ca = 0; ca < 4; ca++)
                for (int cb = 0; cb < 4; cb++) begin
                    logic [31:0] a, b;
                    a = $urandom; b = $urandom;
                    if (v[0]) a[31:16] = corner[ca]; else a[15:0] = corner[ca];
                    if (v[1]) b[31:16] = corner[cb]; else b[15:0] = corner[cb];
                    run_op("R1 R2 R3 halfword", 1'b0, v[0], v[1], a, b);
                end
        for (int i = 0; i < 40; i++) begin
            int unsigned r;
            r = $urandom;
            run_op("R3 halfword random", 1'b0, r[0], r[1], $urandom, $urandom);
        end
    endtask

    task automatic t_word();
        logic [31:0] wc [4] = '{32'h80000000, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h0};
        for (int s = 0; s < 2; s++)
            for (int ca = 0; ca < 4; ca++)
                for (int cb = 0; cb < 4; cb++) begin
                    logic [31:0] b;
                    b = $urandom;
                    if (s == 1) b[31:16] = corner[cb]; else b[15:0] = corner[cb];
                    run_op("R2 R4 word", 1'b1, 1'b0, s[0], wc[ca], b);
                end
        for (int i = 0; i < 40; i++) begin
            int unsigned r;
            r = $urandom;
            run_op("R4 word random", 1'b1, r[0], r[1], $urandom, $urandom);
        end
    endtask

    task automatic t_ignore_sel_a();
        logic [31:0] a, b, first;
        a = 32'h1234_8001; b = 32'hC001_7FFE;
        run_op("R5 sel_a low", 1'b1, 1'b0, 1'b1, a, b);
        first = result_o;
        run_op("R5 sel_a high", 1'b1, 1'b1, 1'b1, a, b);
        check("R5 same result", result_o, first);
    endtask

    task automatic t_min_min();
        run_op("R6 bottom", 1'b0, 1'b0, 1'b0, 32'h0001_8000, 32'h7FFF_8000);
        check("R6 value", result_o, 32'h40000000);
        run_op("R6 top", 1'b0, 1'b1, 1'b1, 32'h8000_0000, 32'h8000_FFFF);
        check("R6 value top", result_o, 32'h40000000);
    endtask

    task automatic t_timing();
        logic [31:0] held;
        // back-to-back strobes
        @(negedge clk);
        mode_word_i = 1'b0; sel_a_hi_i = 1'b0; sel_b_hi_i = 1'b0;
        opa_i = 32'd3; opb_i = 32'd5; exec_i = 1'b1;
        @(negedge clk);
        check("R7 first", result_o, 32'd15);
        check("R7 valid first", {31'd0, result_vld_o}, 32'd1);
        opa_i = 32'd7; opb_i = 32'hFFFF_FFFE;
        @(negedge clk);
        exec_i = 1'b0;
        check("R7 second", result_o, 32'hFFFF_FFF2);
        check("R7 valid second", {31'd0, result_vld_o}, 32'd1);
        held = result_o;
        opa_i = 32'd100; opb_i = 32'd100;
        @(negedge clk);
        check("R8 valid drop", {31'd0, result_vld_o}, 32'd0);
        check("R8 hold", result_o, held);
        @(negedge clk);
        check("R8 hold later", result_o, held);
    endtask

    initial begin
        #(8 * 150000);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_timing();
        t_min_min();
        t_ignore_sel_a();
        t_halfword();
        t_word();
        t_reset();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule